// File: doc/BRIEF.md
# Sequential Integer Divider with Condition Flags

This unit performs the integer divide operations of a processor execution pipeline, one bit per cycle. It covers three forms: a word form that divides a 32-bit dividend by a 16-bit divisor, a long form that divides 32 bits by 32 bits, and a wide form that divides a 64-bit dividend, built from a high and a low operand, by 32 bits. Each form runs signed or unsigned. The unit produces the data for the quotient and remainder registers, a write enable for each, the N, Z, V and C condition flags, and a divide-by-zero trap indication.

The pipeline presents the operands with a one-cycle start strobe while the unit is idle. The unit takes the magnitudes of the operands and runs a fixed number of restoring-division steps, one per quotient bit of the wide dividend. A final cycle then restores the signs, detects overflow and registers the results. The completion strobe tells the register file and the flag logic to commit whatever the write enables and flags show. Register file access and exception vectoring belong to the surrounding pipeline.

Top module: `divq_unit`

## Requirements
- R1: After reset, busy, done, dz_trap, wr_q, wr_r, res_q, res_r and all four flags are 0.
- R2: A start strobe seen while busy is low is accepted. For a nonzero divisor, busy is high from the cycle after start for exactly 65 cycles. done is then high for one cycle, with busy low, in the 66th cycle after the start cycle. A start seen while busy is high is ignored, and the operand inputs are only sampled with an accepted start.
- R3: A zero divisor sets dz_trap and done in the cycle after start. busy never rises, no write enable is set, and all four flags keep their previous values. For the word form only divisor[15:0] counts toward the zero test.
- R4: Every completion without a trap leaves flag_c at 0, including a completion that overflows.
- R5: The form select is 2'b00 for the word form, 2'b01 for the long form, 2'b10 for the wide form, and 2'b11 behaves as the long form. In the word form, dvd_lo is the dividend and divisor[15:0] is the divisor. Both are sign-extended when sgn is 1. A result that does not overflow sets res_q = {remainder[15:0], quotient[15:0]} with wr_q=1 and wr_r=0. N is quotient bit 15 and Z is set when quotient[15:0] is zero.
- R6: Word form overflow occurs when the unsigned quotient exceeds 0xFFFF, or when the signed quotient lies outside -32768..32767.
- R7: When a divide overflows, V=1, Z=0, C=0, N equals the cur_n input latched at start, and wr_q and wr_r are both 0.
- R8: The long form never overflows. res_q is the low 32 bits of the quotient, so -2^31 / -1 yields 0x80000000, and res_r is the remainder. V=0, N is quotient bit 31, Z is set for a zero quotient, and wr_q=1.
- R9: The wide form divides {dvd_hi, dvd_lo} by the 32-bit divisor. It overflows when the quotient exceeds 0xFFFFFFFF unsigned, or lies outside -2^31..2^31-1 signed. Without overflow, its results and flags follow R8.
- R10: In the long and wide forms, wr_r = !same_reg (latched at start) when the result is written. When both destinations are the same register, only the quotient is written.
- R11: Signed quotients truncate toward zero, and a nonzero remainder takes the sign of the dividend. For example, word -7 / 2 gives quotient -3 and remainder -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operand strobe, taken when idle |
| form | input | 2 | Divide form select |
| sgn | input | 1 | 1 for signed division |
| dvd_hi | input | 32 | Upper dividend half (wide form) |
| dvd_lo | input | 32 | Dividend, or lower dividend half |
| divisor | input | 32 | Divisor |
| same_reg | input | 1 | Quotient and remainder share a register |
| cur_n | input | 1 | Present N flag, kept on overflow |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion strobe |
| dz_trap | output | 1 | Divide-by-zero trap, with done |
| wr_q | output | 1 | Quotient register write enable, with done |
| wr_r | output | 1 | Remainder register write enable, with done |
| res_q | output | 32 | Quotient register data |
| res_r | output | 32 | Remainder register data |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Random operands of every form and signedness are mixed with small divisors, so that word and wide quotients land on both sides of the overflow limit, and with occasional zero divisors, including word divisors with only high bits set. Directed quotients of exactly -32768, 32768, 0xFFFF, 0x10000, 0xFFFFFFFF and 2^32 show whether the limit is off by one or assumes the wrong sign. The -2^31 / -1 long case shows whether the long form wrongly applies an overflow test. Cases with mixed signs and odd values separate truncation toward zero from flooring, and a same-register destination and a second start pulse during a run check the write-enable choice and whether the unit latched its operands.

// File: rtl/divq_unit.sv
module divq_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      form,
  input  logic            sgn,
  input  logic [XLEN-1:0] dvd_hi,
  input  logic [XLEN-1:0] dvd_lo,
  input  logic [XLEN-1:0] divisor,
  input  logic            same_reg,
  input  logic            cur_n,
  output logic            busy,
  output logic            done,
  output logic            dz_trap,
  output logic            wr_q,
  output logic            wr_r,
  output logic [XLEN-1:0] res_q,
  output logic [XLEN-1:0] res_r,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v,
  output logic            flag_c
);
  localparam int HLEN  = XLEN / 2;
  localparam int DLEN  = 2 * XLEN;
  localparam int STEPS = DLEN;
  localparam int CW    = $clog2(STEPS);
  localparam logic [DLEN-1:0] ONE = {{(DLEN-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_t;
  state_t state;

  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] acc, dvs_r;
  logic [DLEN-1:0] quo;
  logic [1:0]      r_form;
  logic            r_sgn, r_same, r_curn, r_negq, r_negr;

  wire in_word = (form == 2'b00);
  wire in_wide = (form == 2'b10);

  wire [DLEN-1:0] dvd_ext = in_wide ? {dvd_hi, dvd_lo}
                          : {{XLEN{sgn & dvd_lo[XLEN-1]}}, dvd_lo};
  wire [XLEN-1:0] dvs_ext = in_word ? {{HLEN{sgn & divisor[HLEN-1]}}, divisor[HLEN-1:0]}
                          : divisor;
  wire            dvd_neg = sgn & dvd_ext[DLEN-1];
  wire            dvs_neg = sgn & dvs_ext[XLEN-1];
  wire [DLEN-1:0] dvd_mag = dvd_neg ? -dvd_ext : dvd_ext;
  wire [XLEN-1:0] dvs_mag = dvs_neg ? -dvs_ext : dvs_ext;
  wire            dvs_zero = (dvs_ext == '0);

  wire [XLEN:0]   trial = {acc, quo[DLEN-1]};
  wire            fits  = (trial >= {1'b0, dvs_r});
  wire [XLEN-1:0] diff  = trial[XLEN-1:0] - dvs_r;

  wire [XLEN-1:0] sq = r_negq ? -quo[XLEN-1:0] : quo[XLEN-1:0];
  wire [XLEN-1:0] sr = r_negr ? -acc : acc;

  logic [DLEN-1:0] lim;
  logic            lim_on;
  always_comb begin
    lim    = '1;
    lim_on = 1'b0;
    if (r_form == 2'b00) begin
      lim_on = 1'b1;
      lim = r_sgn ? (ONE << (HLEN-1)) - (r_negq ? '0 : ONE) : (ONE << HLEN) - ONE;
    end else if (r_form == 2'b10) begin
      lim_on = 1'b1;
      lim = r_sgn ? (ONE << (XLEN-1)) - (r_negq ? '0 : ONE) : (ONE << XLEN) - ONE;
    end
  end
  wire ovf = lim_on && (quo > lim);
  wire r_word = (r_form == 2'b00);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      acc     <= '0;
      dvs_r   <= '0;
      quo     <= '0;
      r_form  <= '0;
      r_sgn   <= 1'b0;
      r_same  <= 1'b0;
      r_curn  <= 1'b0;
      r_negq  <= 1'b0;
      r_negr  <= 1'b0;
      done    <= 1'b0;
      dz_trap <= 1'b0;
      wr_q    <= 1'b0;
      wr_r    <= 1'b0;
      res_q   <= '0;
      res_r   <= '0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_v  <= 1'b0;
      flag_c  <= 1'b0;
    end else begin
      done    <= 1'b0;
      dz_trap <= 1'b0;
      wr_q    <= 1'b0;
      wr_r    <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (dvs_zero) begin
            done    <= 1'b1;
            dz_trap <= 1'b1;
          end else begin
            state  <= S_RUN;
            cnt    <= '0;
            acc    <= '0;
            quo    <= dvd_mag;
            dvs_r  <= dvs_mag;
            r_form <= form;
            r_sgn  <= sgn;
            r_same <= same_reg;
            r_curn <= cur_n;
            r_negq <= dvd_neg ^ dvs_neg;
            r_negr <= dvd_neg;
          end
        end
        S_RUN: begin
          acc <= fits ? diff : trial[XLEN-1:0];
          quo <= {quo[DLEN-2:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(STEPS-1)) state <= S_FIX;
        end
        S_FIX: begin
          state  <= S_IDLE;
          done   <= 1'b1;
          flag_c <= 1'b0;
          if (ovf) begin
            flag_v <= 1'b1;
            flag_z <= 1'b0;
            flag_n <= r_curn;
          end else if (r_word) begin
            res_q  <= {sr[HLEN-1:0], sq[HLEN-1:0]};
            res_r  <= sr;
            wr_q   <= 1'b1;
            flag_v <= 1'b0;
            flag_n <= sq[HLEN-1];
            flag_z <= (sq[HLEN-1:0] == '0);
          end else begin
            res_q  <= sq;
            res_r  <= sr;
            wr_q   <= 1'b1;
            wr_r   <= !r_same;
            flag_v <= 1'b0;
            flag_n <= sq[XLEN-1];
            flag_z <= (sq == '0);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divq_unit_chk.sv
module divq_unit_chk #(
  parameter int XLEN = 32
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic dz_trap,
  input logic wr_q,
  input logic wr_r,
  input logic flag_v,
  input logic flag_z
);
  localparam int RUNLEN = 2 * XLEN + 1;
  localparam int BW = $clog2(RUNLEN + 2);

  logic [BW-1:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (!busy) bcnt <= '0;
    else bcnt <= bcnt + 1'b1;
  end

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == BW'(RUNLEN)));
  a_r2_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap) |-> $past(busy));
  a_r3_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap |-> (done && !wr_q && !wr_r));
  a_r3_trap_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap |-> (!busy && !$past(busy)));
  a_r7_ovf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_v) |-> (!wr_q && !wr_r && !flag_z));
  a_r10_quotient_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_r |-> (wr_q && done));
endmodule

bind divq_unit divq_unit_chk #(.XLEN(XLEN)) u_divq_unit_chk (.*);

// File: tb/test_divq_unit.sv
`timescale 1ns/1ps
module test_divq_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] form = 2'b00;
  logic sgn = 1'b0, same_reg = 1'b0, cur_n = 1'b0;
  logic [31:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic busy, done, dz_trap, wr_q, wr_r;
  logic [31:0] res_q, res_r;
  logic flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic m_n = 1'b0, m_z = 1'b0, m_v = 1'b0, m_c = 1'b0;

  always #2.5 clk = ~clk;

  divq_unit i_divq_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .form(form), .sgn(sgn),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor), .same_reg(same_reg),
    .cur_n(cur_n), .busy(busy), .done(done), .dz_trap(dz_trap), .wr_q(wr_q),
    .wr_r(wr_r), .res_q(res_q), .res_r(res_r), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c));

  task automatic chk(input bit ok, input string rq, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] f, input logic s, input logic [31:0] hi,
                        input logic [31:0] lo, input logic [31:0] dv,
                        input logic same, input logic cn, input bit poke,
                        input string tag);
    logic signed [64:0] nv, dvv, qv, rv;
    logic [64:0] an, ad, uq, ur;
    bit wordf, widef, zero, ovf, ewq, ewr;
    logic [31:0] eq, er;
    string fr;
    int cyc;
    wordf = (f == 2'b00);
    widef = (f == 2'b10);
    fr = wordf ? "R5" : (widef ? "R9" : "R8");
    if (widef) nv = s ? {{1{hi[31]}}, hi, lo} : {1'b0, hi, lo};
    else       nv = s ? {{33{lo[31]}}, lo} : {33'd0, lo};
    if (wordf) dvv = s ? {{49{dv[15]}}, dv[15:0]} : {49'd0, dv[15:0]};
    else       dvv = s ? {{33{dv[31]}}, dv} : {33'd0, dv};
    zero = (dvv == 0);
    ovf = 1'b0; eq = '0; er = '0; ewq = 1'b0; ewr = 1'b0;
    if (!zero) begin
      an = nv[64] ? -nv : nv;
      ad = dvv[64] ? -dvv : dvv;
      uq = an / ad;
      ur = an % ad;
      qv = (nv[64] ^ dvv[64]) ? -$signed(uq) : $signed(uq);
      rv = nv[64] ? -$signed(ur) : $signed(ur);
      if (wordf) ovf = s ? (qv < -65'sd32768 || qv > 65'sd32767) : (qv > 65'sd65535);
      else if (widef) ovf = s ? (qv < -65'sd2147483648 || qv > 65'sd2147483647)
                              : (qv > 65'sd4294967295);
      if (ovf) begin
        m_v = 1'b1; m_z = 1'b0; m_n = cn; m_c = 1'b0;
      end else if (wordf) begin
        eq = {rv[15:0], qv[15:0]}; ewq = 1'b1;
        m_v = 1'b0; m_c = 1'b0; m_n = qv[15]; m_z = (qv[15:0] == 0);
      end else begin
        eq = qv[31:0]; er = rv[31:0]; ewq = 1'b1; ewr = !same;
        m_v = 1'b0; m_c = 1'b0; m_n = qv[31]; m_z = (qv[31:0] == 0);
      end
    end
    @(negedge clk);
    form = f; sgn = s; dvd_hi = hi; dvd_lo = lo; divisor = dv;
    same_reg = same; cur_n = cn; start = 1'b1;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        start = 1'b0;
        chk(busy == !zero, "R2", tag, busy, !zero);
      end
      if (poke && cyc == 10) begin
        start = 1'b1; dvd_lo = ~lo; divisor = 32'd3; cur_n = ~cn; same_reg = ~same;
      end
      if (poke && cyc == 11) start = 1'b0;
      if (done || cyc >= 200) break;
    end
    chk(cyc == (zero ? 1 : 66), zero ? "R3" : "R2", tag, cyc, zero ? 1 : 66);
    chk(dz_trap == zero, "R3", tag, dz_trap, zero);
    chk(wr_q == ewq, ovf ? "R7" : fr, tag, wr_q, ewq);
    chk(wr_r == ewr, same ? "R10" : fr, tag, wr_r, ewr);
    chk(flag_v == m_v, wordf ? "R6" : fr, tag, flag_v, m_v);
    chk(flag_n == m_n, ovf ? "R7" : (zero ? "R3" : fr), tag, flag_n, m_n);
    chk(flag_z == m_z, ovf ? "R7" : (zero ? "R3" : fr), tag, flag_z, m_z);
    chk(flag_c == m_c, "R4", tag, flag_c, m_c);
    if (ewq) chk(res_q == eq, fr, tag, res_q, eq);
    if (ewr) chk(res_r == er, fr, tag, res_r, er);
    @(negedge clk);
    chk(done == 1'b0, "R2", tag, done, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk({busy, done, dz_trap, wr_q, wr_r} == 0, "R1", "reset strobes", {busy, done, dz_trap, wr_q, wr_r}, 0);
    chk({res_q, res_r} == 0, "R1", "reset data", {res_q, res_r}, 0);
    chk({flag_n, flag_z, flag_v, flag_c} == 0, "R1", "reset flags", {flag_n, flag_z, flag_v, flag_c}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(2'b00, 1'b1, 0, -32'sd7, 32'd2, 0, 0, 0, "R11 word -7/2");
    run_op(2'b01, 1'b1, 0, 32'd7, -32'sd2, 0, 0, 0, "R11 long 7/-2");
    run_op(2'b10, 1'b1, -32'sd1, -32'sd9, 32'd4, 0, 0, 0, "R11 wide -9/4");
    run_op(2'b00, 1'b1, 0, -32'sd65536, 32'd2, 0, 0, 0, "R6 word -32768 fits");
    run_op(2'b00, 1'b1, 0, 32'd65536, 32'd2, 0, 1, 0, "R6 word 32768 ovf");
    run_op(2'b00, 1'b0, 0, 32'h0000FFFF, 32'd1, 0, 0, 0, "R6 word 0xFFFF fits");
    run_op(2'b00, 1'b0, 0, 32'h00010000, 32'd1, 0, 0, 0, "R7 word ovf n0");
    run_op(2'b01, 1'b1, 0, 32'h80000000, 32'hFFFFFFFF, 0, 1, 0, "R8 min/-1");
    run_op(2'b10, 1'b0, 0, 32'hFFFFFFFF, 32'd1, 0, 0, 0, "R9 wide fits");
    run_op(2'b10, 1'b0, 32'd1, 32'd0, 32'd1, 0, 1, 0, "R9 wide ovf");
    run_op(2'b10, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'd1, 0, 0, 0, "R9 wide min fits");
    run_op(2'b00, 1'b0, 0, 32'd1234, 32'h00010000, 0, 0, 0, "R3 word zero low half");
    run_op(2'b01, 1'b0, 0, 32'd5, 32'd0, 0, 1, 0, "R3 long zero");
    run_op(2'b01, 1'b0, 0, 32'd100, 32'd7, 1, 0, 0, "R10 same reg");
    run_op(2'b11, 1'b1, 0, -32'sd100, 32'd7, 0, 0, 0, "R5 form 3 as long");
    run_op(2'b01, 1'b0, 0, 32'd1000, 32'd9, 0, 0, 1, "R2 start while busy");
    run_op(2'b01, 1'b0, 0, 32'd0, 32'd9, 0, 0, 0, "R8 zero quotient");

    for (int i = 0; i < 250; i++) begin
      logic [1:0] f;
      logic [31:0] hi, lo, dv;
      int sel;
      f = 2'($urandom % 4);
      hi = ($urandom % 2) ? $urandom : 32'($urandom % 4);
      lo = ($urandom % 3 == 0) ? 32'($urandom % 70000) : $urandom;
      sel = $urandom % 20;
      if (sel == 0) dv = 32'd0;
      else if (sel < 10) dv = 32'($urandom % 16) | 32'd1;
      else dv = $urandom;
      run_op(f, 1'($urandom % 2), hi, lo, dv, 1'($urandom % 2), 1'($urandom % 2),
             ($urandom % 25 == 0), "random");
    end
    summary();
  end
endmodule